// File: doc/BRIEF.md
# Twiddled Texture Detwiddle Address Generator

This block turns a texture stored in recursive quadrant order into raster order. A source stream delivers the stored elements one after another; for each one the block states where it belongs in a linear image: its x and y position, the destination address (y times row stride plus x) and, on the final element, a last flag. Width and height are powers of two, given as log2 values and captured on a start pulse. Inside a square, every level of the recursion visits its four quadrants as upper-left, lower-left, upper-right, lower-right. As a result the element index interleaves the coordinate bits, with the y bit below the x bit at every level.

A texture that is not square is handled as a row of squares along its longer axis. The side of each square equals the shorter dimension. Three pixel sizes are supported. For 8-bit and 16-bit pixels each source element gives one output. For 4-bit pixels each source byte holds one vertical pair of pixels. Two bytes make a 2x2 cell, and the block re-pairs their nibbles into two destination bytes, one for each row.

The control is a five-state machine. ST_IDLE goes to ST_TAKE_A on start. ST_TAKE_A goes to ST_SEND_A on a source handshake, or to ST_TAKE_B when in 4-bit pair mode. ST_TAKE_B goes to ST_SEND_A on a source handshake. ST_SEND_A goes to ST_SEND_B in pair mode on an output handshake; otherwise it goes to ST_TAKE_A, or to ST_IDLE after the final element. ST_SEND_B goes to ST_TAKE_A, or to ST_IDLE after the final element.

Top module: `detwiddle_gen`

## Requirements
- R1: After reset the block is idle: src_ready, out_valid and out_last are all 0.
- R2: A start pulse seen while idle captures cfg_log_w, cfg_log_h and cfg_pix, and src_ready is 1 one cycle later. While a job runs, start and changes to the cfg inputs have no effect on the outputs.
- R3: In a square of side 2^s, the element with index k maps to the following position: bit 2i of k gives y bit i, and bit 2i+1 of k gives x bit i.
- R4: When width exceeds height, square t (covering indices t*H*H onward) is placed at x offset t*H.
- R5: When height exceeds width, square t is placed at y offset t*W.
- R6: A 1x1 texture in any pixel mode takes one source element and produces one output at x=0, y=0, address 0, with out_last set and data passed as for 8-bit.
- R7: cfg_pix uses 00 for 4-bit, 01 for 8-bit, and 10 or 11 for 16-bit. In 8-bit and 16-bit modes out_addr = y*W + x in elements. 16-bit data passes whole; 8-bit data is the low source byte with the upper bits 0.
- R8: In 4-bit mode (both sides at least 2), two source bytes b0 and b1 produce two outputs at the even cell x. The first is at row y with data {b1[3:0], b0[3:0]}. The second is at row y+1 with data {b1[7:4], b0[7:4]}. The address is row*(W/2) + x/2 in bytes.
- R9: out_last is 1 only on the final output of a job, and the block is idle in the cycle after that output is accepted.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_x, out_y, out_addr, out_data and out_last stay unchanged.
- R11: src_ready and out_valid are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job with the current cfg values |
| cfg_log_w | input | LOG_W | log2 of texture width (0..MAX_LOG2) |
| cfg_log_h | input | LOG_W | log2 of texture height (0..MAX_LOG2) |
| cfg_pix | input | 2 | Pixel size: 00 4-bit, 01 8-bit, 1x 16-bit |
| src_valid | input | 1 | Source element present |
| src_ready | output | 1 | Block accepts a source element |
| src_data | input | DATA_W | Source element (low byte used in 4/8-bit modes) |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer accepts the output |
| out_x | output | MAX_LOG2 | Destination pixel x |
| out_y | output | MAX_LOG2 | Destination pixel y |
| out_addr | output | 2*MAX_LOG2 | Destination address (elements, or bytes in 4-bit mode) |
| out_data | output | DATA_W | Destination data |
| out_last | output | 1 | Final output of the job |

## Verification
If the element count or the captured shape is wrong, the error appears at the ports on the very next output. The address jumps off the quadrant pattern, or a tile lands at the wrong offset, or out_last comes early or late. A bad nibble pairing appears in the data of the first 4-bit cell. A wrong state shows up as src_ready and out_valid being 1 together, or as an output changing while it is stalled, and the checker reports this in the same cycle. Random shapes in all three modes, with random stalls on both sides, are checked output by output against a reference model that descends the quadrants.

// File: rtl/detw_pkg.sv
package detw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE_A,
        ST_TAKE_B,
        ST_SEND_A,
        ST_SEND_B
    } detw_state_e;

    typedef enum logic [1:0] {
        PIX_4   = 2'd0,
        PIX_8   = 2'd1,
        PIX_16  = 2'd2,
        PIX_16X = 2'd3
    } detw_pix_e;

endpackage

// File: rtl/detw_coord.sv
// Maps a pixel index in quadrant order to raster x/y, including tiling of
// rectangles into squares along the longer axis.
module detw_coord #(
    parameter int MAX_LOG2 = 10,
    parameter int LOG_W    = 4,
    localparam int IDX_W   = 2 * MAX_LOG2
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [LOG_W-1:0]    lw,
    input  logic [LOG_W-1:0]    lh,
    output logic [MAX_LOG2-1:0] x,
    output logic [MAX_LOG2-1:0] y
);
    logic [LOG_W-1:0]    side;
    logic                wide;
    logic [MAX_LOG2-1:0] xi;
    logic [MAX_LOG2-1:0] yi;
    logic [IDX_W-1:0]    tile;
    logic [IDX_W-1:0]    tile_off;

    assign side = (lw < lh) ? lw : lh;
    assign wide = (lw > lh);

    for (genvar b = 0; b < MAX_LOG2; b++) begin : g_bit
        assign yi[b] = (LOG_W'(b) < side) ? idx[2*b]     : 1'b0;
        assign xi[b] = (LOG_W'(b) < side) ? idx[2*b + 1] : 1'b0;
    end

    assign tile     = idx >> {side, 1'b0};
    assign tile_off = tile << side;

    always_comb begin
        if (wide) begin
            x = xi | tile_off[MAX_LOG2-1:0];
            y = yi;
        end else begin
            x = xi;
            y = yi | tile_off[MAX_LOG2-1:0];
        end
    end
endmodule

// File: rtl/detw_addr.sv
// Linear destination address: y*W + x, halved for packed 4-bit rows.
module detw_addr #(
    parameter int MAX_LOG2 = 10,
    parameter int LOG_W    = 4,
    localparam int IDX_W   = 2 * MAX_LOG2
) (
    input  logic [MAX_LOG2-1:0] x,
    input  logic [MAX_LOG2-1:0] y,
    input  logic [LOG_W-1:0]    lw,
    input  logic                half,
    output logic [IDX_W-1:0]    addr
);
    logic [IDX_W-1:0] full;

    assign full = ({{MAX_LOG2{1'b0}}, y} << lw) | {{MAX_LOG2{1'b0}}, x};
    assign addr = half ? (full >> 1) : full;
endmodule

// File: rtl/detw_nibble.sv
// Re-pairs the nibbles of two vertical-pair bytes into one row byte.
module detw_nibble (
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    input  logic       lower_row,
    output logic [7:0] row_byte
);
    assign row_byte = lower_row ? {b1[7:4], b0[7:4]} : {b1[3:0], b0[3:0]};
endmodule

// File: rtl/detwiddle_gen.sv
module detwiddle_gen #(
    parameter int MAX_LOG2 = 10,
    parameter int DATA_W   = 16,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int IDX_W   = 2 * MAX_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LOG_W-1:0]    cfg_log_w,
    input  logic [LOG_W-1:0]    cfg_log_h,
    input  logic [1:0]          cfg_pix,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic [DATA_W-1:0]   src_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [MAX_LOG2-1:0] out_x,
    output logic [MAX_LOG2-1:0] out_y,
    output logic [IDX_W-1:0]    out_addr,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_last
);
    import detw_pkg::*;

    localparam int PAD_W = DATA_W - 8;

    detw_state_e      state, state_nx;
    logic [LOG_W-1:0] lw_q, lh_q;
    logic [1:0]       pix_q;
    logic             pair_q;
    logic [IDX_W-1:0] cnt, total_m1, base_idx;
    logic [DATA_W-1:0] word_a;
    logic [7:0]       byte_b;
    logic             final_q;

    // Job size from the cfg inputs, captured on start
    logic [LOG_W:0]   cfg_sum;
    logic [IDX_W:0]   n_all, n_src, n_src_m1;
    logic             pair_n;

    assign cfg_sum  = {1'b0, cfg_log_w} + {1'b0, cfg_log_h};
    assign n_all    = (IDX_W + 1)'(1) << cfg_sum;
    assign pair_n   = (cfg_pix == PIX_4) && (cfg_sum != '0);
    assign n_src    = pair_n ? (n_all >> 1) : n_all;
    assign n_src_m1 = n_src - (IDX_W + 1)'(1);

    logic take_hs, send_hs, is_last_src;
    assign take_hs     = src_ready && src_valid;
    assign send_hs     = out_valid && out_ready;
    assign is_last_src = (cnt == total_m1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)   state_nx = ST_TAKE_A;
            ST_TAKE_A: if (take_hs) state_nx = pair_q ? ST_TAKE_B : ST_SEND_A;
            ST_TAKE_B: if (take_hs) state_nx = ST_SEND_A;
            ST_SEND_A: if (send_hs) state_nx = pair_q  ? ST_SEND_B :
                                               final_q ? ST_IDLE : ST_TAKE_A;
            ST_SEND_B: if (send_hs) state_nx = final_q ? ST_IDLE : ST_TAKE_A;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Job and element registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_q     <= '0;
            lh_q     <= '0;
            pix_q    <= PIX_8;
            pair_q   <= 1'b0;
            cnt      <= '0;
            total_m1 <= '0;
            base_idx <= '0;
            word_a   <= '0;
            byte_b   <= '0;
            final_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                lw_q     <= cfg_log_w;
                lh_q     <= cfg_log_h;
                pix_q    <= cfg_pix;
                pair_q   <= pair_n;
                cnt      <= '0;
                total_m1 <= n_src_m1[IDX_W-1:0];
                final_q  <= 1'b0;
            end
            if (state == ST_TAKE_A && src_valid) begin
                word_a   <= src_data;
                base_idx <= pair_q ? {cnt[IDX_W-2:0], 1'b0} : cnt;
                cnt      <= cnt + 1'b1;
                if (!pair_q && is_last_src) final_q <= 1'b1;
            end
            if (state == ST_TAKE_B && src_valid) begin
                byte_b   <= src_data[7:0];
                cnt      <= cnt + 1'b1;
                if (is_last_src) final_q <= 1'b1;
            end
        end
    end

    // Position and data path
    logic [MAX_LOG2-1:0] cx, cy, row_y;
    logic                lower_row;
    logic [7:0]          nib_byte;

    assign lower_row = (state == ST_SEND_B);
    assign row_y     = cy + MAX_LOG2'(lower_row);

    detw_coord #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_coord (
        .idx (base_idx),
        .lw  (lw_q),
        .lh  (lh_q),
        .x   (cx),
        .y   (cy)
    );

    detw_addr #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_addr (
        .x    (cx),
        .y    (row_y),
        .lw   (lw_q),
        .half (pair_q),
        .addr (out_addr)
    );

    detw_nibble u_nibble (
        .b0        (word_a[7:0]),
        .b1        (byte_b),
        .lower_row (lower_row),
        .row_byte  (nib_byte)
    );

    // Outputs
    always_comb begin
        src_ready = (state == ST_TAKE_A) || (state == ST_TAKE_B);
        out_valid = (state == ST_SEND_A) || (state == ST_SEND_B);
        out_x     = cx;
        out_y     = row_y;
        if (pair_q)        out_data = {{PAD_W{1'b0}}, nib_byte};
        else if (pix_q[1]) out_data = word_a;
        else               out_data = {{PAD_W{1'b0}}, word_a[7:0]};
        out_last  = final_q && (((state == ST_SEND_A) && !pair_q) ||
                                (state == ST_SEND_B));
    end
endmodule

// File: rtl/detw_checker.sv
module detw_checker #(
    parameter int MAX_LOG2 = 10,
    parameter int DATA_W   = 16,
    localparam int LOG_W   = $clog2(MAX_LOG2 + 1),
    localparam int IDX_W   = 2 * MAX_LOG2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                src_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic                out_last,
    input logic [MAX_LOG2-1:0] out_x,
    input logic [MAX_LOG2-1:0] out_y,
    input logic [IDX_W-1:0]    out_addr,
    input logic [DATA_W-1:0]   out_data,
    input logic [LOG_W-1:0]    lw,
    input logic                pair
);
    // R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_ready && out_valid));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
            $stable(out_data) && $stable(out_last) && $stable(out_x) && $stable(out_y)));

    // R9
    last_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2
    start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !src_ready && !out_valid) |=> src_ready);

    // R7
    x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_x} < ((MAX_LOG2 + 1)'(1) << lw)));

    // R8
    even_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pair) |-> !out_x[0]);
endmodule

bind detwiddle_gen detw_checker #(.MAX_LOG2(MAX_LOG2), .DATA_W(DATA_W)) u_detw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_ready (src_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .lw        (lw_q),
    .pair      (pair_q)
);

// File: tb/test_detwiddle_gen.sv
`timescale 1ns/1ps
module test_detwiddle_gen;
    localparam int MAX_LOG2 = 10;
    localparam int DATA_W   = 16;
    localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
    localparam int IDX_W    = 2 * MAX_LOG2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LOG_W-1:0] cfg_log_w = '0, cfg_log_h = '0;
    logic [1:0] cfg_pix = 2'd1;
    logic src_valid = 1'b0, src_ready;
    logic [DATA_W-1:0] src_data = '0;
    logic out_valid, out_ready = 1'b0;
    logic [MAX_LOG2-1:0] out_x, out_y;
    logic [IDX_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic out_last;

    always #4 clk = ~clk;

    detwiddle_gen #(.MAX_LOG2(MAX_LOG2), .DATA_W(DATA_W)) i_detwiddle_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_log_w(cfg_log_w), .cfg_log_h(cfg_log_h), .cfg_pix(cfg_pix),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_x(out_x), .out_y(out_y), .out_addr(out_addr),
        .out_data(out_data), .out_last(out_last)
    );

    int checks = 0;
    int fails  = 0;
    logic [15:0] mem [0:1023];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference position by quadrant descent (upper-left, lower-left,
    // upper-right, lower-right), then tiling along the longer axis.
    task automatic ref_xy(input int k, input int lw, input int lh,
                          output int x, output int y);
        int s, tile, w;
        s = (lw < lh) ? lw : lh;
        tile = k >> (2 * s);
        w = k & ((1 << (2 * s)) - 1);
        x = 0; y = 0;
        for (int l = s - 1; l >= 0; l--) begin
            int q;
            q = (w >> (2 * l)) & 3;
            if (q == 1 || q == 3) y += (1 << l);
            if (q == 2 || q == 3) x += (1 << l);
        end
        if (lw > lh) x += tile << s;
        else         y += tile << s;
    endtask

    task automatic run_job(input int mode, input int lw, input int lh,
                           input string tag, input bit inject);
        int n, n_src, n_out, e, o, cyc;
        bit pair, stalled;
        logic [63:0] sv_addr, sv_data;
        logic sv_last;
        n = 1 << (lw + lh);
        pair = (mode == 0) && (lw + lh != 0);
        n_src = pair ? n / 2 : n;
        n_out = n_src;
        for (int i = 0; i < n_src; i++) mem[i] = 16'($urandom);

        @(negedge clk);
        cfg_pix = 2'(mode); cfg_log_w = LOG_W'(lw); cfg_log_h = LOG_W'(lh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_log_w = LOG_W'($urandom % 6); cfg_log_h = LOG_W'($urandom % 6);
        cfg_pix = 2'($urandom);
        chk(src_ready === 1'b1 && out_valid === 1'b0, "R2", "ready after start",
            {62'd0, src_ready, out_valid}, 64'd2);

        e = 0; o = 0; cyc = 0; stalled = 1'b0;
        sv_addr = '0; sv_data = '0; sv_last = 1'b0;
        while (o < n_out && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (stalled) begin
                chk(out_valid === 1'b1 && 64'(out_addr) == sv_addr &&
                    64'(out_data) == sv_data && out_last == sv_last,
                    "R10", "held while stalled", 64'(out_addr), sv_addr);
            end
            src_valid = (e < n_src) && ($urandom % 4 != 0);
            src_data  = (e < n_src) ? mem[e] : 16'h0;
            if (src_valid && src_ready) e++;
            out_ready = ($urandom % 4 != 0);
            start = inject && (cyc == 3);
            if (inject) begin
                cfg_log_w = LOG_W'($urandom % 6);
                cfg_pix = 2'($urandom);
            end
            if (out_valid && out_ready) begin
                int x, y, ey, ea;
                logic [15:0] ed;
                chk(!src_ready, "R11", "ready with valid", {63'd0, src_ready}, 64'd0);
                if (pair) begin
                    int c;
                    logic [7:0] b0, b1;
                    c = o >> 1;
                    ref_xy(4 * c, lw, lh, x, y);
                    ey = y + (o & 1);
                    ea = ey * ((1 << lw) / 2) + x / 2;
                    b0 = mem[2 * c][7:0];
                    b1 = mem[2 * c + 1][7:0];
                    ed = (o & 1) ? {8'h0, b1[7:4], b0[7:4]} : {8'h0, b1[3:0], b0[3:0]};
                end else begin
                    ref_xy(o, lw, lh, x, y);
                    ey = y;
                    ea = y * (1 << lw) + x;
                    ed = (mode >= 2) ? mem[o] : {8'h0, mem[o][7:0]};
                end
                chk(int'(out_x) == x && int'(out_y) == ey && int'(out_addr) == ea,
                    tag, "position/address",
                    {12'd0, out_x, out_y, 32'(out_addr)},
                    {12'd0, 10'(x), 10'(ey), 32'(ea)});
                chk(out_data == ed, pair ? "R8" : "R7", "data", 64'(out_data), 64'(ed));
                chk(out_last == (o == n_out - 1), "R9", "last flag",
                    {63'd0, out_last}, {63'd0, o == n_out - 1});
                o++;
            end
            stalled = out_valid && !out_ready;
            sv_addr = 64'(out_addr); sv_data = 64'(out_data); sv_last = out_last;
        end
        chk(cyc < 20000, tag, "job completes", 64'(cyc), 64'd20000);
        @(negedge clk);
        src_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
        chk(src_ready === 1'b0 && out_valid === 1'b0, "R9", "idle after last",
            {62'd0, src_ready, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(src_ready === 1'b0 && out_valid === 1'b0 && out_last === 1'b0, "R1",
            "reset idle", {61'd0, src_ready, out_valid, out_last}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_ready === 1'b0 && out_valid === 1'b0, "R1", "idle after reset",
            {62'd0, src_ready, out_valid}, 64'd0);

        run_job(1, 2, 2, "R3", 1'b0);   // 8-bit 4x4 square
        run_job(2, 3, 3, "R3", 1'b1);   // 16-bit 8x8, start pulsed mid-job (R2)
        run_job(2, 3, 1, "R4", 1'b0);   // 16-bit 8x2 wide
        run_job(1, 1, 3, "R5", 1'b0);   // 8-bit 2x8 tall
        run_job(3, 0, 2, "R5", 1'b0);   // code 11 as 16-bit, 1x4
        run_job(0, 0, 0, "R6", 1'b0);   // 4-bit 1x1
        run_job(1, 0, 0, "R6", 1'b0);   // 8-bit 1x1
        run_job(0, 2, 2, "R8", 1'b0);   // 4-bit 4x4
        run_job(0, 3, 2, "R8", 1'b1);   // 4-bit 8x4 wide
        run_job(0, 1, 4, "R8", 1'b0);   // 4-bit 2x16 tall
        run_job(2, 5, 5, "R7", 1'b0);   // 16-bit 32x32
        for (int j = 0; j < 10; j++) begin
            int m, a, b;
            m = $urandom % 4;
            a = $urandom % 5;
            b = $urandom % 5;
            if (m == 0 && (a == 0 || b == 0) && (a + b != 0)) begin
                if (a == 0) a = 1;
                if (b == 0) b = 1;
            end
            run_job(m, a, b, (a > b) ? "R4" : (b > a) ? "R5" : "R3", j[0]);
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule